// File: doc/BRIEF.md
# Two-Stage DAC Code Stepper

This block holds the digital codes for a two-level DAC arrangement that steers an oscillator control voltage. Two 8-bit coarse codes set the upper and lower reference levels. A 12-bit fine code places the output between those two levels. Software can load any of the three codes, and a fourth register that holds the step size, through a simple write port. Two asynchronous hardware pulse inputs move the fine code up or down by the programmed step size. Stepping clamps at the ends of the 12-bit range and does not wrap.

The block is built around a four-state controller:

- `ST_IDLE`: nothing to apply.
- `ST_WRITE`: a latched register write is applied on the next edge.
- `ST_UP`: the fine code is increased by the step size.
- `ST_DOWN`: the fine code is decreased by the step size.

Every edge computes the next state from the current inputs:

- A write moves the controller to `ST_WRITE`. A write wins over any step event in the same cycle.
- A lone up event moves it to `ST_UP`.
- A lone down event moves it to `ST_DOWN`.
- Anything else, including up and down events together, moves it to `ST_IDLE`.

The output stage updates the registered codes from the state. It raises a one-cycle update strobe whenever a code actually changes.

Top module: `dstep_ctrl`

## Requirements
- R1: After reset the fine code is 0x000, the upper coarse code is 0xFF, the lower coarse code is 0x00, the step size is 1 and `update` is low.
- R2: A write sampled with `wr_en` high updates the register chosen by `wr_sel`: 0 selects fine, 1 selects the upper coarse code, 2 selects the lower coarse code and 3 selects the step size. Coarse codes take bits [7:0] of `wr_data`. The new value is visible at the outputs after the second rising edge, counting the edge that samples the write.
- R3: A write to the step size register (`wr_sel` = 3) changes no output code and raises no strobe.
- R4: Each rising edge on `step_up` adds the step size to the fine code exactly once, however long the pulse is held. The input passes through two synchronizer flops and an edge detector, and the new code appears on the fourth rising edge after the input rises.
- R5: Each rising edge on `step_dn` subtracts the step size from the fine code exactly once, with the same latency as R4.
- R6: An up step whose result would exceed 4095 leaves the fine code at 4095.
- R7: A down step whose result would fall below 0 leaves the fine code at 0.
- R8: Up and down edges detected in the same cycle leave the fine code unchanged and raise no strobe.
- R9: A write sampled in the same cycle as a detected step edge is applied, and that step edge is discarded.
- R10: `update` is high for exactly one cycle, aligned with the new codes, when any output code changes. It stays low when a write or step leaves all codes as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write request |
| wr_sel | input | 2 | Register select (0 fine, 1 upper coarse, 2 lower coarse, 3 step) |
| wr_data | input | 12 | Write data |
| step_up | input | 1 | Asynchronous step-up pulse |
| step_dn | input | 1 | Asynchronous step-down pulse |
| fine_code | output | 12 | Fine DAC code |
| coarse_hi | output | 8 | Upper coarse reference code |
| coarse_lo | output | 8 | Lower coarse reference code |
| update | output | 1 | One-cycle strobe when any code changes |

## Verification
The bench drives pulses held for several cycles. A design without edge detection would step the fine code several times per pulse and end up at the wrong code.

Large step sizes push the fine code against 4095 and against 0. A design that wraps instead of clamping would show a small or a very large code at those points.

Three same-cycle collisions are aligned on purpose:

- up and down edges together;
- a write landing on the same edge as a detected step;
- a write of an unchanged value.

A design with the wrong priority would show a stepped code instead of the written one. A design whose strobe only follows writes would assert `update` with no code change.

// File: rtl/dstep_pkg.sv
package dstep_pkg;
    parameter int FINE_W   = 12;
    parameter int COARSE_W = 8;
    parameter int SEL_W    = 2;

    typedef enum logic [1:0] {
        SEL_FINE = 2'd0,
        SEL_HI   = 2'd1,
        SEL_LO   = 2'd2,
        SEL_STEP = 2'd3
    } sel_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_UP    = 2'd2,
        ST_DOWN  = 2'd3
    } state_e;
endpackage

// File: rtl/dstep_sync_edge.sv
module dstep_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic evt
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[DEPTH-2:0], din};
    end

    assign evt = sh_q[STAGES-1] & ~sh_q[STAGES];

    // R4/R5: an edge event lasts a single cycle
    a_r4_evt_single: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> !evt);
endmodule

// File: rtl/dstep_fsm.sv
module dstep_fsm
    import dstep_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [FINE_W-1:0] wr_data,
    input  logic              up_evt,
    input  logic              dn_evt,
    output state_e            state_q,
    output logic [SEL_W-1:0]  cmd_sel_q,
    output logic [FINE_W-1:0] cmd_data_q
);
    state_e state_d;

    always_comb begin
        state_d = ST_IDLE;
        if (wr_en)                 state_d = ST_WRITE;
        else if (up_evt && !dn_evt) state_d = ST_UP;
        else if (dn_evt && !up_evt) state_d = ST_DOWN;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cmd_sel_q  <= '0;
            cmd_data_q <= '0;
        end else begin
            state_q <= state_d;
            if (wr_en) begin
                cmd_sel_q  <= wr_sel;
                cmd_data_q <= wr_data;
            end
        end
    end

    a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> state_q == ST_WRITE);

    a_r8_both_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (up_evt && dn_evt && !wr_en) |=> state_q == ST_IDLE);
endmodule

// File: rtl/dstep_regs.sv
module dstep_regs
    import dstep_pkg::*;
#(
    parameter logic [FINE_W-1:0]   FINE_RST = '0,
    parameter logic [COARSE_W-1:0] HI_RST   = '1,
    parameter logic [COARSE_W-1:0] LO_RST   = '0,
    parameter logic [FINE_W-1:0]   STEP_RST = FINE_W'(1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  state_e              state,
    input  logic [SEL_W-1:0]    cmd_sel,
    input  logic [FINE_W-1:0]   cmd_data,
    output logic [FINE_W-1:0]   fine_q,
    output logic [COARSE_W-1:0] hi_q,
    output logic [COARSE_W-1:0] lo_q,
    output logic                update_q
);
    localparam int SUM_W = FINE_W + 1;
    localparam logic [FINE_W-1:0] FINE_MAX = '1;

    logic [FINE_W-1:0]   step_q, step_d, fine_d;
    logic [COARSE_W-1:0] hi_d, lo_d;
    logic [SUM_W-1:0]    sum;
    logic                chg;

    always_comb begin
        fine_d = fine_q;
        hi_d   = hi_q;
        lo_d   = lo_q;
        step_d = step_q;
        sum    = {1'b0, fine_q} + {1'b0, step_q};
        unique case (state)
            ST_IDLE: ;
            ST_WRITE: begin
                unique case (sel_e'(cmd_sel))
                    SEL_FINE: fine_d = cmd_data;
                    SEL_HI:   hi_d   = cmd_data[COARSE_W-1:0];
                    SEL_LO:   lo_d   = cmd_data[COARSE_W-1:0];
                    SEL_STEP: step_d = cmd_data;
                endcase
            end
            ST_UP:   fine_d = sum[FINE_W] ? FINE_MAX : sum[FINE_W-1:0];
            ST_DOWN: fine_d = (fine_q < step_q) ? '0 : fine_q - step_q;
        endcase
        chg = (fine_d != fine_q) || (hi_d != hi_q) || (lo_d != lo_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fine_q   <= FINE_RST;
            hi_q     <= HI_RST;
            lo_q     <= LO_RST;
            step_q   <= STEP_RST;
            update_q <= 1'b0;
        end else begin
            fine_q   <= fine_d;
            hi_q     <= hi_d;
            lo_q     <= lo_d;
            step_q   <= step_d;
            update_q <= chg;
        end
    end

    a_r6_up_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_UP |=> fine_q >= $past(fine_q));

    a_r7_down_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_DOWN |=> fine_q <= $past(fine_q));

    a_r10_strobe_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        update_q |-> (fine_q != $past(fine_q)) || (hi_q != $past(hi_q))
                     || (lo_q != $past(lo_q)));

    a_r10_quiet_when_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !update_q |-> $stable(fine_q) && $stable(hi_q) && $stable(lo_q));
endmodule

// File: rtl/dstep_ctrl.sv
module dstep_ctrl
    import dstep_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [SEL_W-1:0]    wr_sel,
    input  logic [FINE_W-1:0]   wr_data,
    input  logic                step_up,
    input  logic                step_dn,
    output logic [FINE_W-1:0]   fine_code,
    output logic [COARSE_W-1:0] coarse_hi,
    output logic [COARSE_W-1:0] coarse_lo,
    output logic                update
);
    localparam int N_PULSE = 2;

    logic [N_PULSE-1:0] raw, evt;
    state_e             state;
    logic [SEL_W-1:0]   cmd_sel;
    logic [FINE_W-1:0]  cmd_data;

    assign raw = {step_dn, step_up};

    for (genvar g = 0; g < N_PULSE; g++) begin : g_sync
        dstep_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (raw[g]),
            .evt   (evt[g])
        );
    end

    dstep_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .up_evt     (evt[0]),
        .dn_evt     (evt[1]),
        .state_q    (state),
        .cmd_sel_q  (cmd_sel),
        .cmd_data_q (cmd_data)
    );

    dstep_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state),
        .cmd_sel  (cmd_sel),
        .cmd_data (cmd_data),
        .fine_q   (fine_code),
        .hi_q     (coarse_hi),
        .lo_q     (coarse_lo),
        .update_q (update)
    );
endmodule

// File: tb/dstep_ctrl_tb.sv
module dstep_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        int          due;
        logic [11:0] fine;
        logic [7:0]  hi;
        logic [7:0]  lo;
        logic        upd;
        int          req;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [11:0] wr_data = '0;
    logic        step_up = 1'b0;
    logic        step_dn = 1'b0;
    logic [11:0] fine_code;
    logic [7:0]  coarse_hi, coarse_lo;
    logic        update;

    int    cyc = 0;
    int    nvec = 0;
    int    nfail = 0;
    item_t q[$];

    int m_fine = 0, m_hi = 8'hFF, m_lo = 0, m_step = 1;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dstep_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .step_up(step_up), .step_dn(step_dn),
        .fine_code(fine_code), .coarse_hi(coarse_hi), .coarse_lo(coarse_lo),
        .update(update)
    );

    // monitor: compares outputs against queued expectations
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            item_t it;
            it = q.pop_front();
            nvec++;
            if (it.due < cyc || fine_code !== it.fine || coarse_hi !== it.hi ||
                coarse_lo !== it.lo || update !== it.upd) begin
                nfail++;
                $display("FAIL R%0d cyc %0d: got fine=%h hi=%h lo=%h upd=%b exp fine=%h hi=%h lo=%h upd=%b",
                         it.req, cyc, fine_code, coarse_hi, coarse_lo, update,
                         it.fine, it.hi, it.lo, it.upd);
            end
        end
    end

    task automatic push(input int due, input logic upd, input int req);
        q.push_back('{due, 12'(m_fine), 8'(m_hi), 8'(m_lo), upd, req});
        q.push_back('{due + 1, 12'(m_fine), 8'(m_hi), 8'(m_lo), 1'b0, req});
    endtask

    task automatic drain();
        while (q.size() > 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic model_write(input int sel, input int data, output logic chg);
        int of = m_fine, oh = m_hi, ol = m_lo;
        case (sel)
            0: m_fine = data & 12'hFFF;
            1: m_hi   = data & 8'hFF;
            2: m_lo   = data & 8'hFF;
            default: m_step = data & 12'hFFF;
        endcase
        chg = (of != m_fine) || (oh != m_hi) || (ol != m_lo);
    endtask

    task automatic do_write(input int sel, input int data, input int req);
        logic chg;
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'(sel); wr_data = 12'(data);
        model_write(sel, data, chg);
        push(cyc + 2, chg, req);
        @(negedge clk);
        wr_en = 1'b0;
        drain();
    endtask

    task automatic do_step(input logic up, input logic dn, input int req);
        int of = m_fine;
        @(negedge clk);
        step_up = up; step_dn = dn;
        if (up && !dn) m_fine = (m_fine + m_step > 4095) ? 4095 : m_fine + m_step;
        if (dn && !up) m_fine = (m_fine < m_step) ? 0 : m_fine - m_step;
        push(cyc + 4, m_fine != of, req);
        repeat (5) @(negedge clk);   // held long: still one step
        step_up = 1'b0; step_dn = 1'b0;
        drain();
    endtask

    // R9: write lands on the same edge that samples the up event
    task automatic do_prio(input int data);
        logic chg;
        int c;
        @(negedge clk);
        step_up = 1'b1;
        c = cyc;
        @(negedge clk);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'd0; wr_data = 12'(data);
        model_write(0, data, chg);
        push(c + 4, chg, 9);
        @(negedge clk);
        wr_en = 1'b0;
        repeat (2) @(negedge clk);
        step_up = 1'b0;
        drain();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        nvec++;
        if (fine_code !== 12'h000 || coarse_hi !== 8'hFF || coarse_lo !== 8'h00 || update !== 1'b0) begin
            nfail++;
            $display("FAIL R1 reset: got fine=%h hi=%h lo=%h upd=%b exp 000 ff 00 0",
                     fine_code, coarse_hi, coarse_lo, update);
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        do_step(1'b1, 1'b0, 1);     // R1: reset step size 1 -> fine 1
        do_write(0, 12'h123, 2);    // R2 fine
        do_write(1, 12'hAC0, 2);    // R2 upper coarse takes low 8 bits
        do_write(2, 12'h040, 2);    // R2 lower coarse
        do_write(3, 12'h010, 3);    // R3 step size: no output change
        do_step(1'b1, 1'b0, 4);     // R4 -> 0x133
        do_step(1'b0, 1'b1, 5);     // R5 -> 0x123
        do_write(3, 12'h800, 3);    // R3
        do_step(1'b1, 1'b0, 4);     // R4 -> 0x923
        do_step(1'b1, 1'b0, 6);     // R6 clamp 0xFFF
        do_step(1'b1, 1'b0, 6);     // R6 stays, no strobe
        do_step(1'b0, 1'b1, 5);     // R5 -> 0x7FF
        do_step(1'b0, 1'b1, 7);     // R7 clamp 0
        do_step(1'b0, 1'b1, 7);     // R7 stays at 0
        do_write(0, 12'h400, 2);
        do_step(1'b1, 1'b1, 8);     // R8 both: unchanged
        do_write(2, 12'h040, 10);   // R10 same value, no strobe
        do_prio(12'h555);           // R9

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nvec++;
        nfail++;
        $display("FAIL watchdog expired at cyc %0d", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule